// File: doc/BRIEF.md
# Field Blanking Regenerator and Gun Calibration Sequencer

This block sits behind a sandcastle level decoder in a television video path. It receives the decoded horizontal pulse flag and the composite blanking flag, recognises the start of each field's vertical interval, and numbers the lines of that interval. From this count it rebuilds a composite blanking output whose vertical part always covers exactly 23 lines, however long the incoming vertical part was, provided that part was long enough to be trusted.

Within the stretched interval the block runs a fixed calibration schedule for the picture tube's three guns. It strobes a drive test pulse into green, red and blue on three consecutive lines, blanks all guns for one line so leakage can be measured, and then strobes a low-level cut-off test pulse into green, red and blue on the next three lines. Alongside the test pulses it raises per-channel sample enables and a strobe that grounds the current-measurement resistor while the high drive currents flow. If the incoming vertical part is too short, the block raises an error flag, ends its vertical output early and issues no test pulse for that field.

A line of the input is taken as vertically blanked once the blanking flag has stayed high for `DET_CYC` clock cycles without a break. Horizontal blanking is shorter than that, so only the vertical part triggers a field.

Top module: `bcal_seq`

## Requirements
- R1: When the blanking input has stayed high for `DET_CYC` consecutive clocks and no field is already in progress, a field starts: that line is line 1, and each later rising edge of the horizontal pulse input advances the line number by one.
- R2: When the field is valid, the stretched vertical blanking covers lines 1 to 23 and ends at the horizontal pulse that begins line 24, whether the blanking input fell earlier or is still high.
- R3: If the blanking input falls while the line number is 11 or less, `err_o` goes high, the stretched vertical blanking ends at once, and `err_o` stays high until the next field starts (it clears at that start).
- R4: A field that ends early under R3 produces no drive, cut-off, all-blank, resistor or sample strobe.
- R5: On lines 17, 18 and 19 of a valid field `drive_o` is one-hot on green, red and blue in that order; bit 0 is red, bit 1 is green, bit 2 is blue (the same mapping holds for `cutoff_o` and `sample_o`).
- R6: On line 20 of a valid field `allblk_o` is high and no drive or cut-off strobe is active.
- R7: On lines 21, 22 and 23 of a valid field `cutoff_o` is one-hot on green, red and blue in that order.
- R8: `rgnd_o` is high on lines 17 to 19 of a valid field and low on every other line.
- R9: Each bit of `sample_o` is high exactly on the lines where the same channel has a drive or cut-off pulse, so at most one bit is high at a time.
- R10: `blank_o` is the OR of the blanking input and the stretched vertical blanking.
- R11: After reset all outputs are low.
- R12: A blanking input that stays high past line 23 does not start a second field; after line 23 no strobe is produced until the input has gone low and a new field starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hp_i | input | 1 | Decoded horizontal pulse flag |
| blk_i | input | 1 | Decoded composite blanking flag |
| blank_o | output | 1 | Regenerated composite blanking |
| drive_o | output | 3 | Drive test pulse insert per channel (bit 0 red, 1 green, 2 blue) |
| cutoff_o | output | 3 | Cut-off test pulse insert per channel |
| allblk_o | output | 1 | All-gun blank for the leakage line |
| rgnd_o | output | 1 | Measurement-resistor grounding strobe |
| sample_o | output | 3 | Per-channel sample enable |
| err_o | output | 1 | Incoming vertical part too short |

## Verification
The hardest situation to reach is the boundary between a vertical part that falls on line 11 and one that falls on line 12, together with vertical parts that outlast line 23, since each needs dozens of precisely shaped lines before any output can differ. The bench therefore sweeps the length of the incoming vertical part across every value from very short to well past the stretched length, builds each field line by line with real horizontal blanking around it, and at the middle of every line compares every output with a line-number schedule computed in the bench. The error flag is also checked in the lead-in lines of the following field, where it must still hold the previous field's outcome.

// File: rtl/bcal_pkg.sv
package bcal_pkg;

  localparam int NCH  = 3;
  localparam int CH_R = 0;
  localparam int CH_G = 1;
  localparam int CH_B = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VERT = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  // position of a channel within each three-line test group: green, red, blue
  function automatic int slot_of(input int ch);
    case (ch)
      CH_G:    slot_of = 0;
      CH_R:    slot_of = 1;
      default: slot_of = 2;
    endcase
  endfunction

endpackage

// File: rtl/bcal_vdet.sv
module bcal_vdet #(
  parameter int DET_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hp_i,
  input  logic blk_i,
  output logic blk_s,
  output logic hp_rise,
  output logic vstart
);

  localparam int RUN_W = $clog2(DET_CYC + 1);

  logic [1:0]       hp_sync;
  logic [1:0]       blk_sync;
  logic             hp_d;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_n;
  logic             run_en;

  // next-state logic
  always_comb begin
    blk_s   = blk_sync[1];
    hp_rise = hp_sync[1] & ~hp_d;
    run_en  = ~blk_s | (run_q != RUN_W'(DET_CYC));
    run_n   = blk_s ? (run_q + 1'b1) : '0;
    vstart  = blk_s && (run_q == RUN_W'(DET_CYC - 1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_sync  <= '0;
      blk_sync <= '0;
      hp_d     <= 1'b0;
      run_q    <= '0;
    end else begin
      hp_sync  <= {hp_sync[0], hp_i};
      blk_sync <= {blk_sync[0], blk_i};
      hp_d     <= hp_sync[1];
      if (run_en) begin
        run_q <= run_n;
      end
    end
  end

endmodule

// File: rtl/bcal_linecnt.sv
module bcal_linecnt
  import bcal_pkg::*;
#(
  parameter int LINE_W    = 5,
  parameter int MIN_LINES = 11,
  parameter int LAST_LINE = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_s,
  input  logic              hp_rise,
  input  logic              vstart,
  output logic [LINE_W-1:0] line,
  output logic              in_vert,
  output logic              err
);

  seq_state_e        state_q, state_n;
  logic [LINE_W-1:0] cnt_q, cnt_n;
  logic              err_q, err_n;
  logic              upd_en;

  // next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    err_n   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (vstart) begin
          state_n = ST_VERT;
          cnt_n   = LINE_W'(1);
          err_n   = 1'b0;
        end
      end
      ST_VERT: begin
        if (!blk_s && (cnt_q <= LINE_W'(MIN_LINES))) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
          err_n   = 1'b1;
        end else if (hp_rise) begin
          if (cnt_q == LINE_W'(LAST_LINE)) begin
            state_n = blk_s ? ST_HOLD : ST_IDLE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (!blk_s) begin
          state_n = ST_IDLE;
        end
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
    upd_en  = (state_n != state_q) || (cnt_n != cnt_q) || (err_n != err_q);
    line    = cnt_q;
    in_vert = (state_q == ST_VERT);
    err     = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      err_q   <= err_n;
    end
  end

endmodule

// File: rtl/bcal_calgen.sv
module bcal_calgen
  import bcal_pkg::*;
#(
  parameter int LINE_W      = 5,
  parameter int FIRST_DRIVE = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line,
  input  logic              in_vert,
  input  logic              blk_s,
  output logic              blank_o,
  output logic [NCH-1:0]    drive_o,
  output logic [NCH-1:0]    cutoff_o,
  output logic              allblk_o,
  output logic              rgnd_o,
  output logic [NCH-1:0]    sample_o
);

  localparam int LEAK_LINE = FIRST_DRIVE + NCH;
  localparam int FIRST_CUT = LEAK_LINE + 1;
  localparam int LAST_DRV  = FIRST_DRIVE + NCH - 1;

  logic [NCH-1:0] drv_n, cut_n, smp_n;
  logic           blank_n, allblk_n, rgnd_n;

  // per-channel line decode
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int SLOT = slot_of(g);
    always_comb begin
      drv_n[g] = in_vert && (line == LINE_W'(FIRST_DRIVE + SLOT));
      cut_n[g] = in_vert && (line == LINE_W'(FIRST_CUT + SLOT));
      smp_n[g] = drv_n[g] | cut_n[g];
    end
  end

  always_comb begin
    blank_n  = blk_s | in_vert;
    allblk_n = in_vert && (line == LINE_W'(LEAK_LINE));
    rgnd_n   = in_vert && (line >= LINE_W'(FIRST_DRIVE)) && (line <= LINE_W'(LAST_DRV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_o  <= 1'b0;
      drive_o  <= '0;
      cutoff_o <= '0;
      allblk_o <= 1'b0;
      rgnd_o   <= 1'b0;
      sample_o <= '0;
    end else begin
      blank_o  <= blank_n;
      drive_o  <= drv_n;
      cutoff_o <= cut_n;
      allblk_o <= allblk_n;
      rgnd_o   <= rgnd_n;
      sample_o <= smp_n;
    end
  end

endmodule

// File: rtl/bcal_seq.sv
module bcal_seq #(
  parameter int DET_CYC     = 64,
  parameter int MIN_LINES   = 11,
  parameter int FIRST_DRIVE = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hp_i,
  input  logic       blk_i,
  output logic       blank_o,
  output logic [2:0] drive_o,
  output logic [2:0] cutoff_o,
  output logic       allblk_o,
  output logic       rgnd_o,
  output logic [2:0] sample_o,
  output logic       err_o
);

  localparam int LAST_LINE = FIRST_DRIVE + 2 * bcal_pkg::NCH;
  localparam int LINE_W    = $clog2(LAST_LINE + 1);

  logic [1:0]        rst_q;
  logic              rst_int_n;
  logic              blk_s, hp_rise, vstart;
  logic [LINE_W-1:0] line;
  logic              in_vert;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= '0;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_q[1];

  bcal_vdet #(
    .DET_CYC (DET_CYC)
  ) u_vdet (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hp_i    (hp_i),
    .blk_i   (blk_i),
    .blk_s   (blk_s),
    .hp_rise (hp_rise),
    .vstart  (vstart)
  );

  bcal_linecnt #(
    .LINE_W    (LINE_W),
    .MIN_LINES (MIN_LINES),
    .LAST_LINE (LAST_LINE)
  ) u_linecnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .blk_s   (blk_s),
    .hp_rise (hp_rise),
    .vstart  (vstart),
    .line    (line),
    .in_vert (in_vert),
    .err     (err_o)
  );

  bcal_calgen #(
    .LINE_W      (LINE_W),
    .FIRST_DRIVE (FIRST_DRIVE)
  ) u_calgen (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .line     (line),
    .in_vert  (in_vert),
    .blk_s    (blk_s),
    .blank_o  (blank_o),
    .drive_o  (drive_o),
    .cutoff_o (cutoff_o),
    .allblk_o (allblk_o),
    .rgnd_o   (rgnd_o),
    .sample_o (sample_o)
  );

endmodule

// File: rtl/bcal_seq_chk.sv
module bcal_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       blank_o,
  input logic [2:0] drive_o,
  input logic [2:0] cutoff_o,
  input logic       allblk_o,
  input logic       rgnd_o,
  input logic [2:0] sample_o,
  input logic       err_o
);

  assert_samp_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sample_o));

  assert_samp_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o == (drive_o | cutoff_o));

  assert_drive_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_o));

  assert_green_then_red_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_o[1]) |-> drive_o[0]);

  assert_drv_cut_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !((|drive_o) && (|cutoff_o)));

  assert_rgnd_with_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rgnd_o == (|drive_o));

  assert_leak_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    allblk_o |-> (drive_o == 3'b000 && cutoff_o == 3'b000));

  assert_err_no_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (drive_o == 3'b000 && cutoff_o == 3'b000 && !allblk_o && !rgnd_o));

  assert_cal_in_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|drive_o) || (|cutoff_o) || allblk_o) |-> blank_o);

endmodule

bind bcal_seq bcal_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .blank_o  (blank_o),
  .drive_o  (drive_o),
  .cutoff_o (cutoff_o),
  .allblk_o (allblk_o),
  .rgnd_o   (rgnd_o),
  .sample_o (sample_o),
  .err_o    (err_o)
);

// File: tb/bcal_seq_bench.sv
module bcal_seq_bench;

  localparam int LINE_CYC = 40;
  localparam int HBLANK   = 6;
  localparam int HPULSE   = 3;
  localparam int MID      = 20;
  localparam int MINL     = 11;
  localparam int STRETCH  = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hp = 1'b0;
  logic       blk = 1'b0;
  logic       blank_o, allblk_o, rgnd_o, err_o;
  logic [2:0] drive_o, cutoff_o, sample_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bcal_seq #(.DET_CYC(8)) u_bcal_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hp_i     (hp),
    .blk_i    (blk),
    .blank_o  (blank_o),
    .drive_o  (drive_o),
    .cutoff_o (cutoff_o),
    .allblk_o (allblk_o),
    .rgnd_o   (rgnd_o),
    .sample_o (sample_o),
    .err_o    (err_o)
  );

  // bit 0 red, bit 1 green, bit 2 blue; group order green, red, blue
  function automatic logic [2:0] slot_bits(input int s);
    case (s)
      0:       slot_bits = 3'b010;
      1:       slot_bits = 3'b001;
      default: slot_bits = 3'b100;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected outputs at the middle of line i of a field (i<=0: lead-in)
  task automatic verify(input int i, input int vlen, input bit sh, input bit psh);
    bit       vert, blkin, lng, e_err, e_all, e_rg;
    logic [2:0] e_drv, e_cut;
    lng   = !sh;
    vert  = (i >= 1) && (sh ? (i <= vlen) : (i <= STRETCH));
    blkin = (i >= 1) && (i <= vlen);
    e_drv = (lng && i >= 17 && i <= 19) ? slot_bits(i - 17) : 3'b000;
    e_cut = (lng && i >= 21 && i <= 23) ? slot_bits(i - 21) : 3'b000;
    e_all = lng && (i == 20);
    e_rg  = lng && i >= 17 && i <= 19;
    e_err = (i <= 0) ? psh : (sh && i >= vlen + 1);
    if (i == 1)                  chk("R1", "blank line1", int'(blank_o), 1);
    else if (sh && i == vlen + 1) chk("R3", "blank after short drop", int'(blank_o), 0);
    else if (lng && i > vlen && i <= STRETCH) chk("R2", "stretched blank", int'(blank_o), 1);
    else if (lng && i == STRETCH + 1) chk("R2", "blank end line24", int'(blank_o), int'(blkin));
    else                          chk("R10", "blank", int'(blank_o), int'(blkin | vert));
    if (sh) begin
      chk("R4", "drive short", int'(drive_o), 0);
      chk("R4", "cutoff short", int'(cutoff_o), 0);
      chk("R4", "allblk/rgnd short", int'({allblk_o, rgnd_o}), 0);
    end else if (i > STRETCH) begin
      chk("R12", "no strobe past 23", int'({drive_o, cutoff_o, allblk_o, rgnd_o}), 0);
    end else begin
      chk("R5", "drive", int'(drive_o), int'(e_drv));
      chk("R7", "cutoff", int'(cutoff_o), int'(e_cut));
      chk("R6", "allblk", int'(allblk_o), int'(e_all));
      chk("R8", "rgnd", int'(rgnd_o), int'(e_rg));
    end
    chk("R9", "sample", int'(sample_o), int'(e_drv | e_cut));
    chk("R3", "err", int'(err_o), int'(e_err));
  endtask

  task automatic do_line(input bit vfull, input int i, input int vlen, input bit sh, input bit psh);
    for (int c = 0; c < LINE_CYC; c++) begin
      @(negedge clk);
      if (c == MID) verify(i, vlen, sh, psh);
      hp  = (c < HPULSE);
      blk = vfull || (c < HBLANK);
    end
  endtask

  initial begin
    bit psh;
    psh = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11", "reset outputs", int'({blank_o, drive_o, cutoff_o, allblk_o, rgnd_o, sample_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "outputs after release", int'({blank_o, drive_o, cutoff_o, allblk_o, rgnd_o, sample_o, err_o}), 0);
    for (int vlen = 2; vlen <= 27; vlen++) begin
      bit sh;
      int last;
      sh   = (vlen + 1 <= MINL);
      last = (vlen + 1 > STRETCH + 1) ? vlen + 1 : STRETCH + 1;
      for (int i = -1; i <= 0; i++) do_line(1'b0, i, vlen, sh, psh);
      for (int i = 1; i <= last; i++) do_line(i <= vlen, i, vlen, sh, psh);
      psh = sh;
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule